// File: doc/BRIEF.md
# Radix-256 Iterative Floating-Point Mantissa Multiplier

This block multiplies two packed floating-point operands. Each operand holds a sign bit, a 15-bit exponent and a 48-bit fractional mantissa. A one-cycle `start` pulse, given while the block is idle, loads both operands. The multiplier mantissa is then retired 8 bits at a time over six accumulation steps. In each step the 8-bit digit selects a multiple of the multiplicand. That multiple is positioned at its digit weight and added into a redundant sum/carry pair through a carry-save stage, so no carry ripples across the word during the iterations. After each step the multiplier register shifts right by 8 positions, and the bits shifted out are discarded.

A single resolve step then adds the sum and carry words into the exact 96-bit product. It normalizes the product by at most one position and can round on the bit just below the kept mantissa. The output carries the new sign, the exponent sum with its correction, and the 48-bit mantissa. `done` pulses when the result appears, and `busy` marks the run.

Top module: `fp_mul_r256`

## Requirements
- R1: While reset is held and after it is released, `done` and `busy` are 0 and `y` is all zeros.
- R2: A `start` seen at a clock edge while `busy` is 0 sets `busy`. The result appears and `done` rises for exactly one cycle at the 7th following edge (six accumulation steps plus one resolve step), and `busy` falls at that same edge.
- R3: With rounding off, the mantissa `y[47:0]` equals bits 95..48 of the exact 96-bit product of the two 48-bit mantissas when bit 95 of that product is 1. Otherwise it equals bits 94..47 (one left shift).
- R4: The exponent `y[62:48]` equals the sum of the operand exponents modulo 2^15. It is decreased by 1 when the one-position left shift of R3 is applied, which includes a zero product.
- R5: The sign `y[63]` equals the XOR of the operand signs.
- R6: When `rnd` was 1 at start, the kept mantissa is incremented if the product bit just below it is 1. If this increment overflows 48 bits, the mantissa becomes 1 followed by 47 zeros and the exponent increases by 1.
- R7: A `start` pulse while `busy` is 1 is ignored. The run in progress completes with its own operands and its own timing.
- R8: `y` holds its value in every cycle except the one in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load operands and begin a multiply (taken only when idle) |
| rnd | input | 1 | Rounding enable for this operation |
| a | input | 64 | Operand A: {sign, exponent[14:0], mantissa[47:0]} |
| b | input | 64 | Operand B: same packing as A |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when `y` is updated |
| y | output | 64 | Product: {sign, exponent[14:0], mantissa[47:0]} |

## Verification
A carry-save word that is wrong in any step, or a digit taken from the wrong multiplier position, stays hidden until the resolve step. It then shows up in the mantissa within seven cycles of `start`. Because one-position normalization depends on the product's top bit, an error in the accumulation can also flip the exponent correction. A wrong step count shows as `done` arriving off the seventh edge. Sweeps over patterned and pseudo-random mantissas make each digit position contribute to the product. A crafted operand pair drives the rounding overflow path, and an injected `start` in mid-run checks that a running operation cannot be disturbed.

// File: rtl/fp_mul_r256.sv
module fp_mul_r256 #(
  parameter int MW = 48,
  parameter int EW = 15,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rnd,
  input  logic [EW+MW:0]      a,
  input  logic [EW+MW:0]      b,
  output logic                busy,
  output logic                done,
  output logic [EW+MW:0]      y
);
  localparam int STEPS = MW / DW;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int PW    = 2 * MW;
  localparam int OW    = 1 + EW + MW;

  logic [MW-1:0] mcand, mplier;
  logic [PW-1:0] acc_s, acc_c;
  logic [EW-1:0] ex;
  logic          sg, rnd_q, fin;
  logic [CW-1:0] cnt;

  logic [PW-1:0] mult, pp, prod;
  assign mult = {{(PW-MW){1'b0}}, mcand} * {{(PW-DW){1'b0}}, mplier[DW-1:0]};
  assign pp   = mult << (DW * cnt);
  assign prod = acc_s + acc_c;

  logic          hi, g, ov;
  logic [MW-1:0] m0, mr, mant;
  logic [EW-1:0] ey;
  assign hi   = prod[PW-1];
  assign m0   = hi ? prod[PW-1:MW] : prod[PW-2:MW-1];
  assign g    = hi ? prod[MW-1] : prod[MW-2];
  assign {ov, mr} = {1'b0, m0} + {{MW{1'b0}}, rnd_q & g};
  assign mant = ov ? {1'b1, {(MW-1){1'b0}}} : mr;
  assign ey   = ex - {{(EW-1){1'b0}}, ~hi} + {{(EW-1){1'b0}}, ov};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fin <= 1'b0; cnt <= '0;
      mcand <= '0; mplier <= '0; acc_s <= '0; acc_c <= '0;
      ex <= '0; sg <= 1'b0; rnd_q <= 1'b0; y <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          fin    <= 1'b0;
          cnt    <= '0;
          mcand  <= a[MW-1:0];
          mplier <= b[MW-1:0];
          acc_s  <= '0;
          acc_c  <= '0;
          ex     <= a[OW-2:MW] + b[OW-2:MW];
          sg     <= a[OW-1] ^ b[OW-1];
          rnd_q  <= rnd;
        end
      end else if (!fin) begin
        acc_s  <= acc_s ^ acc_c ^ pp;
        acc_c  <= ((acc_s & acc_c) | (acc_s & pp) | (acc_c & pp)) << 1;
        mplier <= mplier >> DW;
        cnt    <= cnt + 1'b1;
        fin    <= (cnt == CW'(STEPS - 1));
      end else begin
        y    <= {sg, ey, mant};
        done <= 1'b1;
        busy <= 1'b0;
        fin  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp_mul_r256_chk.sv
module fp_mul_r256_chk #(
  parameter int MW = 48,
  parameter int EW = 15,
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [EW+MW:0] a,
  input logic [EW+MW:0] b,
  input logic           busy,
  input logic           done,
  input logic [EW+MW:0] y
);
  localparam int STEPS = MW / DW;
  localparam int OW    = 1 + EW + MW;

  logic [7:0] len;
  logic       sgn_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0; sgn_q <= 1'b0;
    end else if (start && !busy) begin
      len <= '0; sgn_q <= a[OW-1] ^ b[OW-1];
    end else if (busy) begin
      len <= len + 1'b1;
    end
  end

  // R2: result arrives after the accumulation steps plus one resolve step
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> len == 8'(STEPS + 1));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5 and R7: sign tracks the operands taken at acceptance
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> y[OW-1] == sgn_q);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y));
endmodule

bind fp_mul_r256 fp_mul_r256_chk #(.MW(MW), .EW(EW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
  .busy(busy), .done(done), .y(y)
);

// File: tb/fp_mul_r256_bench.sv
module fp_mul_r256_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rnd = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        busy, done;
  logic [63:0] y;

  int checks = 0, errors = 0, cyc = 0;

  fp_mul_r256 u_fp_mul_r256 (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd(rnd),
    .a(a), .b(b), .busy(busy), .done(done), .y(y)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] z, input logic r);
    logic [95:0] p;
    logic [48:0] m;
    logic [14:0] e;
    logic        gb;
    p = {48'b0, x[47:0]} * {48'b0, z[47:0]};
    e = x[62:48] + z[62:48];
    if (p[95]) begin
      m = {1'b0, p[95:48]}; gb = p[47];
    end else begin
      m = {1'b0, p[94:47]}; gb = p[46]; e = e - 15'd1;
    end
    if (r && gb) m = m + 49'd1;
    if (m[48]) begin
      m = 49'd1 << 47; e = e + 15'd1;
    end
    return {x[63] ^ z[63], e, m[47:0]};
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] v);
    v = v ^ (v << 13); v = v ^ (v >> 7); v = v ^ (v << 17);
    return v;
  endfunction

  task automatic run(input logic [63:0] x, input logic [63:0] z, input logic r, input bit inject);
    logic [63:0] exp, held;
    bit early;
    exp = model(x, z, r);
    early = 0;
    @(negedge clk);
    a = x; b = z; rnd = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = ~x; b = ~z; rnd = ~r;
    chk("R2 busy after start", {63'b0, busy}, 64'd1);
    for (int k = 1; k <= 7; k++) begin
      if (inject && k == 3) begin
        a = 64'h0123456789abcdef; b = 64'hfedcba9876543210; start = 1'b1;
      end
      if (k < 7) begin
        @(negedge clk);
        start = 1'b0;
        if (done) early = 1;
      end else begin
        @(negedge clk);
      end
    end
    chk("R2 no early done", {63'b0, early}, 64'd0);
    chk("R2 done on 7th edge", {62'b0, done, busy}, 64'd2);
    chk(r ? "R6 mantissa" : "R3 mantissa", {16'b0, y[47:0]}, {16'b0, exp[47:0]});
    chk("R4 exponent", {49'b0, y[62:48]}, {49'b0, exp[62:48]});
    chk("R5 sign", {63'b0, y[63]}, {63'b0, exp[63]});
    if (inject) chk("R7 start ignored while busy", y, exp);
    held = y;
    @(negedge clk);
    chk("R2 done one cycle", {63'b0, done}, 64'd0);
    chk("R8 result held", y, held);
  endtask

  initial begin
    logic [63:0] s1, s2;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {busy, done, y[61:0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {busy, done, y[61:0]}, 64'd0);

    run({1'b0, 15'd10, 48'h800000000000}, {1'b0, 15'd20, 48'h800000000000}, 1'b0, 0);
    run({1'b1, 15'd3,  48'hffffffffffff}, {1'b0, 15'd4,  48'hffffffffffff}, 1'b0, 0);
    run({1'b1, 15'h7ff0, 48'hc00000000001}, {1'b1, 15'h0020, 48'ha5a5a5a5a5a5}, 1'b1, 0);
    run({1'b0, 15'd5, 48'h0}, {1'b1, 15'd6, 48'h123456789abc}, 1'b0, 0);
    run({1'b0, 15'd1, 48'd33 << 42}, {1'b0, 15'd1, 48'd34118178995231 << 3}, 1'b1, 0);
    run({1'b0, 15'd1, 48'd33 << 42}, {1'b0, 15'd1, 48'd34118178995231 << 3}, 1'b0, 0);
    run({1'b1, 15'd100, 48'h8000000000ff}, {1'b0, 15'd200, 48'hff0000000001}, 1'b0, 1);

    for (int i = 0; i < 6; i++) begin
      run({1'b0, 15'd7, 48'hffffffffffff}, {1'b0, 15'd9, (48'hff << (8 * i)) | 48'h800000000000}, i[0], 0);
    end

    s1 = 64'h9e3779b97f4a7c15; s2 = 64'h243f6a8885a308d3;
    for (int i = 0; i < 120; i++) begin
      s1 = xs(s1); s2 = xs(s2);
      run({s1[63:48], s1[47:0] | ((i % 4 == 3) ? 48'h0 : 48'h800000000000)},
          {s2[63:48], s2[47:0] | 48'h800000000000}, s1[5], 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule